// File: doc/BRIEF.md
# Serial Flash Command Responder

This block is the command front end of a serial NOR flash target on an SPI bus in mode 0. It oversamples the bus pins with the chip's own clock and takes the first byte after chip select falls as an opcode. It then either answers one of three identification requests or updates two pieces of device state: the write-enable latch and the one-time-programmable (OTP) mode flag. Each identification reply repeats for as long as the host keeps clocking, and stops when chip select rises.

The rest of the chip reads `wel` before it accepts a program, erase or status write. It pulses `op_done` when one of those operations finishes, and that pulse clears the latch. The data output comes as a value plus an enable (`do_o`, `do_oe`). The pad ring turns them into a tri-state pin, so DO is high-impedance whenever `do_oe` is low. The array and the program and erase datapaths live elsewhere.

Top module: `flash_cmd_responder`

## Requirements
- R1: Opcode 06h sets `wel` when chip select rises after exactly eight bits.
- R2: Opcode 04h, when chip select rises after exactly eight bits, clears both `wel` and `otp_mode`.
- R3: Opcode 3Ah, when chip select rises after exactly eight bits, sets `otp_mode` and leaves `wel` unchanged.
- R4: A one-byte command (06h, 04h, 3Ah) whose transaction ends after any bit count other than eight changes neither `wel` nor `otp_mode`.
- R5: After reset `wel`, `otp_mode` and `do_oe` are all 0. A one-cycle pulse on `op_done` clears `wel`, and the pulse wins over a write enable applied in the same cycle.
- R6: Opcode 9Fh is answered with 1Ch, 31h, 13h, and that three-byte sequence repeats until chip select rises.
- R7: Opcode 90h takes three more bytes. Bit 0 of the third byte picks the first reply byte: 0 gives 1Ch, 1 gives 12h. The reply then alternates between 1Ch and 12h.
- R8: Opcode ABh takes three dummy bytes and is then answered with 12h on every byte.
- R9: Any other opcode is ignored. Later bits of that transaction change no state and never enable DO.
- R10: All bytes travel MSB first. DI is sampled on rising SCLK. `do_o` changes only after a falling SCLK. `do_oe` is low during the opcode and the extra bytes, high while reply bits are driven, and low again once chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock (mode 0, idles low) |
| cs_n | input | 1 | Chip select, active low |
| di | input | 1 | Serial data in from the host |
| op_done | input | 1 | One-cycle pulse: a program, erase or status write has finished |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for serial data out |
| wel | output | 1 | Write-enable latch |
| otp_mode | output | 1 | OTP mode flag |

## Verification
A wrong decoder state shows up on DO within one byte time. Reply bytes out of order, the wrong start of the alternating reply, or DO enabled during the extra bytes all appear in the very next byte the host clocks in. A latch that goes wrong at a chip-select boundary shows up on `wel` or `otp_mode` a few clock cycles after chip select rises, which is why every one-byte command is followed by a status check. Wrong reply-index wrap-around only shows after several repeats, so the reads clock out five or more bytes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OP_WREN   = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRDI   = 8'h04;
  localparam logic [BYTE_W-1:0] OP_OTP    = 8'h3A;
  localparam logic [BYTE_W-1:0] OP_JEDEC  = 8'h9F;
  localparam logic [BYTE_W-1:0] OP_MFDEV  = 8'h90;
  localparam logic [BYTE_W-1:0] OP_LEGACY = 8'hAB;

  localparam logic [BYTE_W-1:0] ID_MFR  = 8'h1C;
  localparam logic [BYTE_W-1:0] ID_DEV  = 8'h12;
  localparam logic [BYTE_W-1:0] ID_TYPE = 8'h31;
  localparam logic [BYTE_W-1:0] ID_CAP  = 8'h13;

  // bit positions in the synchronizer vector
  localparam int PIN_SCLK = 0;
  localparam int PIN_CS   = 1;
  localparam int PIN_DI   = 2;
  localparam int PIN_N    = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPCODE, ST_SINGLE, ST_HDR, ST_REPLY, ST_DISCARD
  } fsm_e;

  typedef enum logic [1:0] {
    RK_LEGACY, RK_MFDEV, RK_JEDEC
  } reply_e;

  // byte served at reply position idx
  function automatic logic [BYTE_W-1:0] reply_byte(reply_e k, logic [1:0] idx,
                                                   logic start_dev);
    logic [BYTE_W-1:0] b;
    case (k)
      RK_MFDEV: b = (idx[0] ^ start_dev) ? ID_DEV : ID_MFR;
      RK_JEDEC: begin
        case (idx)
          2'd0:    b = ID_MFR;
          2'd1:    b = ID_TYPE;
          default: b = ID_CAP;
        endcase
      end
      default: b = ID_DEV;
    endcase
    return b;
  endfunction

  // reply position after a byte has been sent
  function automatic logic [1:0] next_idx(reply_e k, logic [1:0] idx);
    logic [1:0] n;
    if (k == RK_JEDEC) n = (idx == 2'd2) ? 2'd0 : idx + 2'd1;
    else               n = {1'b0, ~idx[0]};
    return n;
  endfunction

endpackage

// File: rtl/fcr_sync.sv
module fcr_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/fcr_byte_rx.sv
module fcr_byte_rx
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [BIT_CW-1:0] bit_cnt_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o
);

  logic [BIT_CW-1:0] cnt;
  logic [BYTE_W-2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (clr_i) begin
      cnt <= '0;
    end else if (shift_i) begin
      cnt <= cnt + BIT_CW'(1);
      sh  <= {sh[BYTE_W-3:0], bit_i};
    end
  end

  assign bit_cnt_o   = cnt;
  assign byte_done_o = shift_i && (cnt == BIT_CW'(BYTE_W-1));
  assign byte_o      = {sh, bit_i};

endmodule

// File: rtl/fcr_reply_tx.sv
module fcr_reply_tx
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              fall_i,
  input  logic              active_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BIT_CW-1:0] bit_cnt_i,
  output logic              do_o,
  output logic              oe_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      do_o <= 1'b0;
      oe_o <= 1'b0;
    end else if (stop_i) begin
      oe_o <= 1'b0;
    end else if (fall_i) begin
      oe_o <= active_i;
      if (active_i) do_o <= byte_i[~bit_cnt_i];
    end
  end

endmodule

// File: rtl/flash_cmd_responder.sv
module flash_cmd_responder
  import flash_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HDR_BYTES   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic di,
  input  logic op_done,
  output logic do_o,
  output logic do_oe,
  output logic wel,
  output logic otp_mode
);

  localparam int HCW = $clog2(HDR_BYTES + 1);
  localparam logic [PIN_N-1:0] SYNC_RST = PIN_N'(1) << PIN_CS;

  logic [PIN_N-1:0] raw, syn;
  logic sclk_s, cs_s, di_s, sclk_q, cs_q;

  assign raw[PIN_SCLK] = sclk;
  assign raw[PIN_CS]   = cs_n;
  assign raw[PIN_DI]   = di;

  fcr_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  assign sclk_s = syn[PIN_SCLK];
  assign cs_s   = syn[PIN_CS];
  assign di_s   = syn[PIN_DI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end
  end

  // named internal events, also used by the checker
  logic ev_sclk_rise, ev_sclk_fall, ev_cs_fall, ev_cs_rise, ev_byte_done;
  assign ev_sclk_rise = sclk_s && !sclk_q && !cs_s;
  assign ev_sclk_fall = !sclk_s && sclk_q && !cs_s;
  assign ev_cs_fall   = !cs_s && cs_q;
  assign ev_cs_rise   = cs_s && !cs_q;

  logic [BIT_CW-1:0] bit_cnt;
  logic [BYTE_W-1:0] rx_byte;

  fcr_byte_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clr_i(cs_s), .shift_i(ev_sclk_rise), .bit_i(di_s),
    .bit_cnt_o(bit_cnt), .byte_done_o(ev_byte_done), .byte_o(rx_byte)
  );

  fsm_e              state;
  reply_e            kind;
  logic [BYTE_W-1:0] single_op;
  logic [HCW-1:0]    hdr_left;
  logic [1:0]        idx;
  logic              start_dev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= RK_LEGACY;
      single_op <= '0;
      hdr_left  <= '0;
      idx       <= '0;
      start_dev <= 1'b0;
    end else if (ev_cs_rise) begin
      state <= ST_IDLE;
    end else if (ev_cs_fall) begin
      state <= ST_OPCODE;
    end else if (ev_sclk_rise) begin
      case (state)
        ST_OPCODE: if (ev_byte_done) begin
          idx       <= '0;
          start_dev <= 1'b0;
          case (rx_byte)
            OP_WREN, OP_WRDI, OP_OTP: begin
              state     <= ST_SINGLE;
              single_op <= rx_byte;
            end
            OP_JEDEC: begin
              state <= ST_REPLY;
              kind  <= RK_JEDEC;
            end
            OP_MFDEV: begin
              state    <= ST_HDR;
              kind     <= RK_MFDEV;
              hdr_left <= HCW'(HDR_BYTES);
            end
            OP_LEGACY: begin
              state    <= ST_HDR;
              kind     <= RK_LEGACY;
              hdr_left <= HCW'(HDR_BYTES);
            end
            default: state <= ST_DISCARD;
          endcase
        end
        ST_SINGLE: state <= ST_DISCARD;
        ST_HDR: if (ev_byte_done) begin
          if (hdr_left == HCW'(1)) begin
            state     <= ST_REPLY;
            start_dev <= rx_byte[0];
          end
          hdr_left <= hdr_left - HCW'(1);
        end
        ST_REPLY: if (ev_byte_done) idx <= next_idx(kind, idx);
        default: state <= state;
      endcase
    end
  end

  logic ev_apply, ev_apply_wren, ev_apply_wrdi, ev_apply_otp, in_discard;
  assign ev_apply      = ev_cs_rise && (state == ST_SINGLE);
  assign ev_apply_wren = ev_apply && (single_op == OP_WREN);
  assign ev_apply_wrdi = ev_apply && (single_op == OP_WRDI);
  assign ev_apply_otp  = ev_apply && (single_op == OP_OTP);
  assign in_discard    = (state == ST_DISCARD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel      <= 1'b0;
      otp_mode <= 1'b0;
    end else begin
      if (op_done)            wel <= 1'b0;
      else if (ev_apply_wren) wel <= 1'b1;
      else if (ev_apply_wrdi) wel <= 1'b0;
      if (ev_apply_otp)       otp_mode <= 1'b1;
      else if (ev_apply_wrdi) otp_mode <= 1'b0;
    end
  end

  logic [BYTE_W-1:0] cur_byte;
  assign cur_byte = reply_byte(kind, idx, start_dev);

  fcr_reply_tx u_tx (
    .clk(clk), .rst_n(rst_n), .stop_i(cs_s), .fall_i(ev_sclk_fall),
    .active_i(state == ST_REPLY), .byte_i(cur_byte), .bit_cnt_i(bit_cnt),
    .do_o(do_o), .oe_o(do_oe)
  );

endmodule

// File: rtl/fcr_checker.sv
module fcr_checker (
  input logic clk,
  input logic rst_n,
  input logic op_done,
  input logic wel,
  input logic otp_mode,
  input logic do_o,
  input logic do_oe,
  input logic ev_apply_wren,
  input logic ev_apply_wrdi,
  input logic ev_apply_otp,
  input logic ev_cs_rise,
  input logic ev_sclk_fall,
  input logic in_discard
);

  // R1
  wren_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_apply_wren && !op_done |=> wel);

  // R2
  wrdi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_apply_wrdi |=> !wel && !otp_mode);

  // R3
  otp_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_apply_otp |=> otp_mode);

  // R2
  otp_exit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(otp_mode) |-> $past(ev_apply_wrdi));

  // R4
  wel_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(ev_apply_wren));

  // R5
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !wel);

  // R9
  discard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_discard |-> !do_oe);

  // R10
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cs_rise |=> !do_oe);

  // R10
  oe_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe) |-> $past(ev_sclk_fall));

  // R10
  do_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_sclk_fall |=> $stable(do_o));

endmodule

bind flash_cmd_responder fcr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_done(op_done), .wel(wel), .otp_mode(otp_mode),
  .do_o(do_o), .do_oe(do_oe), .ev_apply_wren(ev_apply_wren),
  .ev_apply_wrdi(ev_apply_wrdi), .ev_apply_otp(ev_apply_otp),
  .ev_cs_rise(ev_cs_rise), .ev_sclk_fall(ev_sclk_fall), .in_discard(in_discard)
);

// File: tb/flash_cmd_responder_tb.sv
module flash_cmd_responder_tb;

  localparam int HP = 8;  // SCLK half period in clk cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, di = 1'b0, op_done = 1'b0;
  logic do_o, do_oe, wel, otp_mode;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic exp_wel = 1'b0, exp_otp = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_responder u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .di(di), .op_done(op_done),
    .do_o(do_o), .do_oe(do_oe), .wel(wel), .otp_mode(otp_mode)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_reply(input logic [7:0] op, input logic [7:0] addr,
                                           input int k);
    if (op == 8'h9F) begin
      if (k % 3 == 0) return 8'h1C;
      if (k % 3 == 1) return 8'h31;
      return 8'h13;
    end
    if (op == 8'h90) return (((k + int'(addr[0])) % 2) == 1) ? 8'h12 : 8'h1C;
    return 8'h12;
  endfunction

  task automatic one_bit(input logic b, output logic dout, output logic oe);
    di = b;
    tick(HP);
    dout = do_o;
    oe = do_oe;
    sclk = 1'b1;
    tick(HP);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output logic oe_any, output logic oe_all);
    logic d, e;
    oe_any = 1'b0;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      one_bit(tx[i], d, e);
      rx[i] = d;
      oe_any |= e;
      oe_all &= e;
    end
  endtask

  task automatic cs_start;
    cs_n = 1'b0;
    tick(HP);
  endtask

  task automatic cs_stop;
    tick(HP);
    cs_n = 1'b1;
    tick(HP);
  endtask

  task automatic check_status(input string req);
    check({req, " wel"}, {7'd0, wel}, {7'd0, exp_wel});
    check({req, " otp"}, {7'd0, otp_mode}, {7'd0, exp_otp});
  endtask

  // one-byte command cut after nbits bits (R1 R2 R3 R4)
  task automatic send_single(input logic [7:0] op, input int nbits, input string req);
    logic d, e;
    cs_start();
    for (int i = 0; i < nbits; i++) one_bit((i < 8) ? op[7-i] : 1'b0, d, e);
    cs_stop();
    if (nbits == 8) begin
      if (op == 8'h06) exp_wel = 1'b1;
      if (op == 8'h04) begin exp_wel = 1'b0; exp_otp = 1'b0; end
      if (op == 8'h3A) exp_otp = 1'b1;
    end
    check_status(req);
  endtask

  // identification read of n reply bytes (R6 R7 R8 R10)
  task automatic run_read(input logic [7:0] op, input logic [7:0] addr, input int n,
                          input string req);
    logic [7:0] rx;
    logic any, all, hdr_oe;
    cs_start();
    xfer(op, rx, hdr_oe, all);
    if (op != 8'h9F) begin
      for (int h = 0; h < 3; h++) begin
        xfer((h == 2) ? addr : 8'($urandom), rx, any, all);
        hdr_oe |= any;
      end
    end
    check("R10 oe during command", {7'd0, hdr_oe}, 8'd0);
    for (int k = 0; k < n; k++) begin
      xfer(8'($urandom), rx, any, all);
      check(req, rx, exp_reply(op, addr, k));
      check("R10 oe during reply", {7'd0, all}, 8'd1);
    end
    cs_stop();
    check("R10 oe after cs", {7'd0, do_oe}, 8'd0);
  endtask

  // unknown opcode followed by a would-be write enable (R9)
  task automatic run_unknown(input logic [7:0] op);
    logic [7:0] rx;
    logic any, all, seen;
    cs_start();
    xfer(op, rx, seen, all);
    xfer(8'h06, rx, any, all);
    seen |= any;
    xfer(8'h9F, rx, any, all);
    seen |= any;
    cs_stop();
    check("R9 oe after unknown", {7'd0, seen}, 8'd0);
    check_status("R9");
  endtask

  task automatic pulse_done;
    @(negedge clk) op_done = 1'b1;
    @(negedge clk) op_done = 1'b0;
    tick(2);
    exp_wel = 1'b0;
    check_status("R5 done");
  endtask

  function automatic bit is_known(input logic [7:0] op);
    return op inside {8'h06, 8'h04, 8'h3A, 8'h9F, 8'h90, 8'hAB};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R5 reset state
    check_status("R5 reset");
    check("R5 reset oe", {7'd0, do_oe}, 8'd0);

    send_single(8'h06, 8, "R1");
    send_single(8'h04, 8, "R2");
    send_single(8'h3A, 8, "R3");
    send_single(8'h06, 8, "R1 in otp");
    send_single(8'h04, 8, "R2 leaves otp");
    send_single(8'h06, 9, "R4 nine bits");
    send_single(8'h06, 7, "R4 seven bits");
    send_single(8'h3A, 16, "R4 sixteen bits");
    send_single(8'h06, 8, "R1");
    pulse_done();

    run_read(8'h9F, 8'h00, 7, "R6 jedec");
    run_read(8'h90, 8'h00, 5, "R7 mfr first");
    run_read(8'h90, 8'h01, 5, "R7 dev first");
    run_read(8'hAB, 8'h00, 4, "R8 legacy");
    run_unknown(8'h5A);
    run_unknown(8'hFF);

    for (int t = 0; t < 30; t++) begin
      int sel;
      logic [7:0] op;
      sel = int'($urandom_range(0, 6));
      case (sel)
        0: op = 8'h06;
        1: op = 8'h04;
        2: op = 8'h3A;
        3: op = 8'h9F;
        4: op = 8'h90;
        5: op = 8'hAB;
        default: op = 8'($urandom);
      endcase
      if (op inside {8'h06, 8'h04, 8'h3A})
        send_single(op, ($urandom_range(0, 4) == 0) ? 7 + 2 * int'($urandom_range(0, 1)) : 8,
                    "R4 random single");
      else if (op inside {8'h9F, 8'h90, 8'hAB})
        run_read(op, 8'($urandom), 1 + int'($urandom_range(0, 4)), "R7 random read");
      else if (!is_known(op))
        run_unknown(op);
      if ($urandom_range(0, 3) == 0) pulse_done();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule